// File: doc/BRIEF.md
# Sequential Vector Magnitude Unit

This block returns the length of a two-component vector, floor(sqrt(a^2 + b^2)), for two 32-bit signed fixed-point samples. A typical use is envelope recovery for an amplitude-modulated signal: the in-phase and quadrature outputs of a coherent detector go in, and the envelope amplitude comes out. The block works one sample pair at a time. It takes up to roughly a hundred and fifty clocks per result, which is far inside a budget of 2000 clocks.

A single iterative shift-and-add squarer is shared in time. It squares |a|, then |b|, and in threshold mode it also squares the threshold. The two squares add into a 64-bit sum. In magnitude mode a restoring square-root recurrence then resolves one root bit per clock, and it uses no multiplier. In threshold mode the root is skipped. The sum of squares is compared directly with the squared threshold, which gives the same less/equal/greater answer as comparing the magnitude with the threshold.

Top module: `vecmag_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `busy_o` is 0, `done_o` is 0, `mag_o` is 0 and `cmp_o` is 0.
- R2: In magnitude mode (`thr_mode_i` = 0) the result `mag_o` equals floor(sqrt(a^2 + b^2)), where `a_i` and `b_i` are two's-complement signed values.
- R3: The most negative input, 32'h80000000, is taken as magnitude 2^31 without overflow, so a = b = -2^31 gives `mag_o` = 3037000499.
- R4: In threshold mode (`thr_mode_i` = 1) `mag_o` is 0 and `cmp_o` is one-hot: bit 0 set when a^2 + b^2 < thr^2, bit 1 set when they are equal, bit 2 set when a^2 + b^2 > thr^2. Here `thr_i` is an unsigned magnitude.
- R5: `done_o` is high for exactly one cycle per calculation. `mag_o` and `cmp_o` hold their values until the next result is presented.
- R6: A `start_i` pulse that arrives while `busy_o` is high is ignored. It does not change the result in flight and it does not produce a second `done_o`.
- R7: `done_o` rises no more than 2000 clocks after the cycle in which `start_i` is accepted.
- R8: In magnitude mode `cmp_o` is 0 when the result is presented.
- R9: `busy_o` is high from the cycle after an accepted start until the result cycle, and it is low in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| thr_mode_i | input | 1 | 1 selects compare against threshold, 0 selects magnitude |
| a_i | input | 32 | First component, signed |
| b_i | input | 32 | Second component, signed |
| thr_i | input | 32 | Threshold magnitude, unsigned |
| busy_o | output | 1 | Calculation in flight |
| done_o | output | 1 | One-cycle result strobe |
| mag_o | output | 32 | Magnitude result |
| cmp_o | output | 3 | One-hot compare result {gt, eq, lt}, 0 when there is no comparison |

## Verification
The embedded assertions check the following on every cycle:
- `done_o` is a single-cycle pulse.
- `cmp_o` is never more than one-hot.
- Each root leaving the recurrence satisfies r^2 <= s < (r+1)^2 for the sum it was given.
- The recurrence remainder stays within its width.
- The latency counter stays under the budget.
- An idle block keeps its outputs steady.

Only the bench scenarios can show the following:
- The full arithmetic against an independently computed floor root, including the sign handling of -2^31 and mixed signs.
- The direction of the threshold comparison.
- That a start issued mid-calculation leaves the first result intact and produces no second strobe.

// File: rtl/vecmag_pkg.sv
// Package: shared types and codes for the vector magnitude unit.
// Assumes: one calculation in flight; state codes are internal only.
package vecmag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQ_A,
        ST_SQ_B,
        ST_SQ_T,
        ST_ROOT
    } vm_state_t;

    // One-hot compare codes: bit0 less, bit1 equal, bit2 greater
    localparam logic [2:0] CMP_NONE = 3'b000;
    localparam logic [2:0] CMP_LT   = 3'b001;
    localparam logic [2:0] CMP_EQ   = 3'b010;
    localparam logic [2:0] CMP_GT   = 3'b100;

endpackage

// File: rtl/vm_square_iter.sv
// Iterative squarer: forms op*op with one shift-and-add step per clock.
// Assumes: go is pulsed only while idle; op is held stable by the caller
// only in the go cycle (it is captured then). prod_o is valid while done_o is high.
module vm_square_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [W-1:0]   op_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [2*W-1:0] mcand_q;
    logic [W-1:0]   mplier_q;
    logic [2*W-1:0] acc_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;
    logic           done_q;

    // Partial-product step: add shifted multiplicand when the current multiplier bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && !busy_q) begin
                mcand_q  <= {{W{1'b0}}, op_i};
                mplier_q <= op_i;
                acc_q    <= '0;
                cnt_q    <= '0;
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                acc_q    <= acc_q + (mplier_q[0] ? mcand_q : '0);
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign prod_o = acc_q;

    // R9: the sequencer never launches a square while one is running
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !go_i);

    // R5: completion strobe of the squarer lasts one cycle
    a_r5_sq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/vm_isqrt_iter.sv
// Integer square root by the restoring digit recurrence, one root bit per clock.
// Assumes: go is pulsed only while idle; rad_i is captured in the go cycle.
// root_o is floor(sqrt(rad)) while done_o is high and holds afterwards.
module vm_isqrt_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [2*W-1:0] rad_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [W-1:0]   root_o
);
    localparam int CW = $clog2(W);
    localparam int RW = W + 2;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [2*W-1:0] rad_q;
    logic [RW-1:0]  rem_q;
    logic [W-1:0]   root_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;
    logic           done_q;

    logic [RW+1:0]  rem_sh;
    logic [RW+2:0]  trial;
    logic           fits;
    logic [RW+1:0]  rem_nx;

    // Trial subtraction of (root<<2)|1 from remainder with two new radicand bits
    always_comb begin
        rem_sh = {rem_q, rad_q[2*W-1 -: 2]};
        trial  = {1'b0, rem_sh} - {3'b000, root_q, 2'b01};
        fits   = !trial[RW+2];
        rem_nx = fits ? trial[RW+1:0] : rem_sh;
    end

    // Recurrence registers: shift radicand, update remainder and root
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && !busy_q) begin
                rad_q  <= rad_i;
                rem_q  <= '0;
                root_q <= '0;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rad_q  <= rad_q << 2;
                rem_q  <= rem_nx[RW-1:0];
                root_q <= {root_q[W-2:0], fits};
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign root_o = root_q;

    // R2: the remainder never needs more than RW bits during the recurrence
    a_r2_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_nx[RW+1:RW] == 2'b00));

    // R9: the sequencer never restarts the root while it is running
    a_r9_root_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !go_i);

endmodule

// File: rtl/vecmag_unit.sv
// Vector magnitude unit: sqrt(a^2+b^2) or a threshold compare of a^2+b^2.
// Assumes: one calculation at a time; starts while busy are dropped;
// thr_i is an unsigned magnitude. Results hold until the next result.
module vecmag_unit
    import vecmag_pkg::*;
#(
    parameter int W      = 32,
    parameter int BUDGET = 2000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         thr_mode_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] thr_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] mag_o,
    output logic [2:0]   cmp_o
);
    localparam int LW = $clog2(BUDGET + 1);

    vm_state_t      state_q;
    logic [W-1:0]   abs_a_q, abs_b_q, thr_q;
    logic           mode_q;
    logic [2*W-1:0] sum_q;
    logic           sq_go_q, rt_go_q;
    logic [W-1:0]   sq_op;
    logic           sq_busy, sq_done;
    logic [2*W-1:0] sq_prod;
    logic           rt_busy, rt_done;
    logic [W-1:0]   rt_root;
    logic           done_q;
    logic [W-1:0]   mag_q;
    logic [2:0]     cmp_q;
    logic [LW-1:0]  lat_q;

    // Two's-complement absolute value; -2^(W-1) maps to 2^(W-1) as unsigned
    function automatic logic [W-1:0] mag_of(input logic [W-1:0] v);
        return v[W-1] ? (~v + 1'b1) : v;
    endfunction

    // Operand select for the shared squarer
    always_comb begin
        unique case (state_q)
            ST_SQ_A: sq_op = abs_a_q;
            ST_SQ_B: sq_op = abs_b_q;
            default: sq_op = thr_q;
        endcase
    end

    vm_square_iter #(.W(W)) u_sq (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (sq_go_q),
        .op_i  (sq_op),
        .busy_o(sq_busy),
        .done_o(sq_done),
        .prod_o(sq_prod)
    );

    vm_isqrt_iter #(.W(W)) u_rt (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (rt_go_q),
        .rad_i (sum_q),
        .busy_o(rt_busy),
        .done_o(rt_done),
        .root_o(rt_root)
    );

    // Sequencer: square a, square b, then root or square threshold and compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            abs_a_q <= '0;
            abs_b_q <= '0;
            thr_q   <= '0;
            mode_q  <= 1'b0;
            sum_q   <= '0;
            sq_go_q <= 1'b0;
            rt_go_q <= 1'b0;
            done_q  <= 1'b0;
            mag_q   <= '0;
            cmp_q   <= CMP_NONE;
        end else begin
            sq_go_q <= 1'b0;
            rt_go_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    abs_a_q <= mag_of(a_i);
                    abs_b_q <= mag_of(b_i);
                    thr_q   <= thr_i;
                    mode_q  <= thr_mode_i;
                    sq_go_q <= 1'b1;
                    state_q <= ST_SQ_A;
                end
                ST_SQ_A: if (sq_done) begin
                    sum_q   <= sq_prod;
                    sq_go_q <= 1'b1;
                    state_q <= ST_SQ_B;
                end
                ST_SQ_B: if (sq_done) begin
                    sum_q <= sum_q + sq_prod;
                    if (mode_q) begin
                        sq_go_q <= 1'b1;
                        state_q <= ST_SQ_T;
                    end else begin
                        rt_go_q <= 1'b1;
                        state_q <= ST_ROOT;
                    end
                end
                ST_SQ_T: if (sq_done) begin
                    mag_q   <= '0;
                    cmp_q   <= (sum_q < sq_prod) ? CMP_LT :
                               (sum_q == sq_prod) ? CMP_EQ : CMP_GT;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_ROOT: if (rt_done) begin
                    mag_q   <= rt_root;
                    cmp_q   <= CMP_NONE;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Latency counter guarding the cycle budget
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) lat_q <= '0;
        else if (lat_q != LW'(BUDGET))     lat_q <= lat_q + 1'b1;
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign mag_o  = mag_q;
    assign cmp_o  = cmp_q;

    // R5: result strobe lasts exactly one cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5: while idle and not restarted the presented result is steady
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(mag_q) && $stable(cmp_q)));

    // R4: compare result is at most one-hot
    a_r4_cmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_q));

    // R2: each root satisfies r^2 <= s < (r+1)^2
    a_r2_root_bracket: assert property (@(posedge clk) disable iff (!rst_n)
        rt_done |-> (({{(W+2){1'b0}}, rt_root} * {{(W+2){1'b0}}, rt_root}) <= {2'b00, sum_q})
               && ((({{(W+2){1'b0}}, rt_root} + 1'b1) * ({{(W+2){1'b0}}, rt_root} + 1'b1)) > {2'b00, sum_q}));

    // R6: a start seen while busy leaves the captured operands untouched
    a_r6_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(abs_a_q) && $stable(abs_b_q) && $stable(mode_q)));

    // R7: a calculation finishes within the cycle budget
    a_r7_budget: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q < LW'(BUDGET));

    // R9: an accepted start makes the block busy in the next cycle
    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

endmodule

// File: tb/tb_vecmag_unit.sv
// Bench for vecmag_unit: vector table walk, random magnitudes, directed corners.
module tb_vecmag_unit;
    localparam int W  = 32;
    localparam int NV = 10;
    localparam int WD = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         thr_mode_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0, thr_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] mag_o;
    logic [2:0]   cmp_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vecmag_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .thr_mode_i(thr_mode_i),
        .a_i(a_i), .b_i(b_i), .thr_i(thr_i),
        .busy_o(busy_o), .done_o(done_o), .mag_o(mag_o), .cmp_o(cmp_o)
    );

    // Stimulus table: {a, b, thr_mode, thr}
    localparam logic [96:0] VEC [NV] = '{
        {32'd0,          32'd0,          1'b0, 32'd0},
        {32'd3,          32'd4,          1'b0, 32'd0},
        {32'hFFFFFFFD,   32'd4,          1'b0, 32'd0},
        {32'h80000000,   32'h80000000,   1'b0, 32'd0},
        {32'h7FFFFFFF,   32'h80000000,   1'b0, 32'd0},
        {32'd1000,       32'd1000,       1'b0, 32'd0},
        {32'd3,          32'd4,          1'b1, 32'd5},
        {32'd3,          32'd4,          1'b1, 32'd4},
        {32'd3,          32'hFFFFFFFC,   1'b1, 32'd6},
        {32'h80000000,   32'd0,          1'b1, 32'hFFFFFFFF}
    };

    function automatic logic [63:0] absq(input logic [31:0] v);
        logic [63:0] m;
        m = v[31] ? (64'd1 << 32) - {32'd0, v} : {32'd0, v};
        return m * m;
    endfunction

    // Floor root by bitwise search over the squared candidate
    function automatic logic [31:0] ref_root(input logic [63:0] s);
        logic [31:0] r;
        logic [31:0] t;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            t = r | (32'd1 << i);
            if ({32'd0, t} * {32'd0, t} <= s) r = t;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Issue one calculation and wait for its strobe; returns cycles to done
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic m,
                       input logic [31:0] t, output int cyc);
        @(negedge clk);
        a_i = a; b_i = b; thr_mode_i = m; thr_i = t; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        check("R9 busy after start", busy_o, 1);
        while (!done_o && cyc < WD) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) begin
            errors++;
            $display("FAIL R7 watchdog no done got 0 expected 1");
        end
    endtask

    task automatic expect_result(input logic [31:0] a, input logic [31:0] b,
                                 input logic m, input logic [31:0] t, input string tag);
        logic [63:0] s;
        logic [63:0] ts;
        logic [2:0]  ec;
        s  = absq(a) + absq(b);
        ts = {32'd0, t} * {32'd0, t};
        ec = (s < ts) ? 3'b001 : (s == ts) ? 3'b010 : 3'b100;
        if (!m) begin
            check({tag, " R2 magnitude"}, mag_o, ref_root(s));
            check({tag, " R8 no compare"}, cmp_o, 0);
        end else begin
            check({tag, " R4 compare"}, cmp_o, ec);
            check({tag, " R4 mag zero"}, mag_o, 0);
        end
        check({tag, " R9 idle at done"}, busy_o, 0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] keep;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 mag", mag_o, 0);
        check("R1 cmp", cmp_o, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][96:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], cyc);
            expect_result(VEC[i][96:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], "table");
            check("R7 latency within budget", (cyc <= 2000), 1);
        end

        // R3: explicit value for two most-negative inputs
        run(32'h80000000, 32'h80000000, 1'b0, 32'd0, cyc);
        check("R3 most negative pair", mag_o, 64'd3037000499);

        // Random magnitude cases
        for (int i = 0; i < 20; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            run(ra, rb, 1'b0, 32'd0, cyc);
            expect_result(ra, rb, 1'b0, 32'd0, "random");
        end

        // R5: done lasts one cycle, result holds while idle
        run(32'd6, 32'd8, 1'b0, 32'd0, cyc);
        keep = mag_o;
        @(negedge clk);
        check("R5 done one cycle", done_o, 0);
        repeat (40) @(negedge clk);
        check("R5 mag holds", mag_o, keep);
        check("R5 cmp holds", cmp_o, 0);

        // R6: start while busy ignored
        run(32'd5, 32'd12, 1'b0, 32'd0, cyc);   // warm result 13
        @(negedge clk);
        a_i = 32'd3; b_i = 32'd4; thr_mode_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        a_i = 32'd20; b_i = 32'd21; thr_mode_i = 1'b1; thr_i = 32'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < WD) begin
            @(negedge clk);
            cyc++;
        end
        check("R6 first result kept", mag_o, 5);
        check("R6 no compare from ignored start", cmp_o, 0);
        cyc = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done_o) cyc++;
        end
        check("R6 no second done", cyc, 0);
        check("R6 idle afterwards", busy_o, 0);

        // R1: reset mid-calculation clears everything
        @(negedge clk);
        a_i = 32'd7; b_i = 32'd24; thr_mode_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy_o, 0);
        check("R1 mag after reset", mag_o, 0);
        rst_n = 1'b1;
        run(32'd7, 32'd24, 1'b0, 32'd0, cyc);
        check("R2 after reset", mag_o, 25);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule